// File: doc/BRIEF.md
# Masked Interrupt Controller

This block collects up to eight interrupt requests and steers a small CPU into a single handler. Each request line is watched for a low-to-high transition, and the transition is latched in a pending byte. A mask byte decides which pending sources may interrupt the CPU. When the CPU signals an instruction boundary and at least one pending source is unmasked, the block does three things at one clock edge:

- it saves the CPU's current program counter in a read-only return register;
- it forces every mask bit to one;
- it then raises a one-cycle take pulse that carries the handler address.

Software reaches the registers over a byte-wide bus with combinational read data. Each 16-bit register is split into two bytes that are written separately, low byte first in the address order. Software acknowledges a source by writing zero to its pending bit.

A two-state sequencer controls entry. In `SEQ_WATCH` it waits. The transition *accept* (boundary high and an unmasked source pending) moves it to `SEQ_ENTER` and captures the PC and the mask. In `SEQ_ENTER` the take pulse is high for one cycle. The transition *resume* returns unconditionally to `SEQ_WATCH`.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the registers read as follows: return address 0x0000, mask 0xFF, pending 0x00, handler 0x0000. The take output is low.
- R2: A low-to-high change on request bit i (i < 6) sets pending bit i at the next clock edge. A request held high does not set the bit again once it has been cleared.
- R3: A bus write to offset 3 clears each pending bit written as 0 and leaves each bit written as 1 unchanged.
- R4: When a request rises in the same cycle that software clears its pending bit, the bit ends up set.
- R5: Pending bits 6 and 7 always read 0, whatever the requests or bus writes.
- R6: A pending bit whose mask bit (offset 2, bit i) is 1 never causes a take.
- R7: When `cpu_boundary` is sampled high at an edge and (pending & ~mask) is nonzero, `take_irq` is high for exactly the following cycle. `handler_addr` always equals the handler register.
- R8: At that same edge the return register captures `cpu_pc` and the mask becomes 0xFF. This overrides a mask write made in the same cycle.
- R9: Bus writes to offsets 0 and 1 have no effect. The return register changes only on interrupt entry.
- R10: Word registers are little-endian. Offset 0 and offset 1 are the low and high return bytes, and offset 4 and offset 5 are the low and high handler bytes. Each byte is written on its own. Offsets 6 and 7 read 0.
- R11: No take occurs unless `cpu_boundary` was high at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 3 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_req | input | 8 | Interrupt request lines |
| cpu_pc | input | 16 | Current program counter |
| cpu_boundary | input | 1 | CPU is at an instruction boundary |
| take_irq | output | 1 | One-cycle redirect pulse |
| handler_addr | output | 16 | Handler address to jump to |

## Verification
The bench builds the block with its default parameters: eight request lines, six of them live, and a 16-bit program counter. With the two reserved lines present, the bench can drive requests and bus writes into bits 6 and 7 and confirm that they stay dead. The same defaults also let it combine a take with a mask write in one cycle, and a rising request with a software clear in one cycle. A behavioural model compares every readable byte and the take outputs on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        SEQ_WATCH = 1'b0,
        SEQ_ENTER = 1'b1
    } seq_state_t;

    localparam logic [2:0] OFF_RET_LO = 3'd0;
    localparam logic [2:0] OFF_RET_HI = 3'd1;
    localparam logic [2:0] OFF_MASK   = 3'd2;
    localparam logic [2:0] OFF_PEND   = 3'd3;
    localparam logic [2:0] OFF_HND_LO = 3'd4;
    localparam logic [2:0] OFF_HND_HI = 3'd5;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NUM_SRC  = 8,
    parameter int LIVE_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] rise
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (i < LIVE_SRC) begin : g_live
            logic req_q;
            logic pend_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    req_q  <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    req_q  <= req[i];
                    // a rising request beats a software clear
                    pend_q <= (pend_q & ~(clr_wr & ~clr_data[i])) | rise[i];
                end
            end
            assign rise[i] = req[i] & ~req_q;
            assign pend[i] = pend_q;
        end else begin : g_rsvd
            logic unused_bits;
            assign unused_bits = req[i] ^ clr_data[i];
            assign rise[i] = 1'b0;
            assign pend[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic active,
    output logic capture,
    output logic take
);
    seq_state_t state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_WATCH;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SEQ_WATCH: if (boundary && active) state_n = SEQ_ENTER; // accept
            SEQ_ENTER: state_n = SEQ_WATCH;                          // resume
            default:   state_n = SEQ_WATCH;
        endcase
    end

    always_comb begin
        capture = 1'b0;
        take    = 1'b0;
        unique case (state_q)
            SEQ_WATCH: capture = boundary && active;
            SEQ_ENTER: take = 1'b1;
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int LIVE_SRC = 6,
    parameter int PC_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [PC_W-1:0]    cpu_pc,
    input  logic               cpu_boundary,
    output logic               take_irq,
    output logic [PC_W-1:0]    handler_addr
);
    localparam int HI_W = PC_W - 8;

    logic [PC_W-1:0]    ret_q, hnd_q;
    logic [NUM_SRC-1:0] mask_q, pend, rise;
    logic               capture, active;

    assign active = |(pend & ~mask_q);

    irq_pending #(.NUM_SRC(NUM_SRC), .LIVE_SRC(LIVE_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .clr_wr   (reg_wr && reg_addr == OFF_PEND),
        .clr_data (reg_wdata[NUM_SRC-1:0]),
        .pend     (pend),
        .rise     (rise)
    );

    irq_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (cpu_boundary),
        .active   (active),
        .capture  (capture),
        .take     (take_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q  <= '0;
            mask_q <= '1;
            hnd_q  <= '0;
        end else begin
            if (capture) ret_q <= cpu_pc;
            if (capture)                          mask_q <= '1;
            else if (reg_wr && reg_addr == OFF_MASK) mask_q <= reg_wdata[NUM_SRC-1:0];
            if (reg_wr && reg_addr == OFF_HND_LO) hnd_q[7:0]    <= reg_wdata;
            if (reg_wr && reg_addr == OFF_HND_HI) hnd_q[PC_W-1:8] <= reg_wdata[HI_W-1:0];
        end
    end

    assign handler_addr = hnd_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_RET_LO: reg_rdata = ret_q[7:0];
            OFF_RET_HI: reg_rdata = 8'(ret_q[PC_W-1:8]);
            OFF_MASK:   reg_rdata = 8'(mask_q);
            OFF_PEND:   reg_rdata = 8'(pend);
            OFF_HND_LO: reg_rdata = hnd_q[7:0];
            OFF_HND_HI: reg_rdata = 8'(hnd_q[PC_W-1:8]);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int PC_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               take,
    input logic               boundary,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] rise,
    input logic [PC_W-1:0]    pc,
    input logic [PC_W-1:0]    ret
);
    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take); // R7
    AST_TAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(pend & ~mask) != '0)); // R6
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary)); // R11
    AST_MASK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (mask == '1)); // R8
    AST_RET_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (ret == $past(pc))); // R8
    AST_RET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> $stable(ret)); // R9
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise))); // R2
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pend[NUM_SRC-1 -: 2] == 2'b00); // R5
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_irq),
    .boundary (cpu_boundary),
    .pend     (pend),
    .mask     (mask_q),
    .rise     (rise),
    .pc       (cpu_pc),
    .ret      (ret_q)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [7:0]  irq_req = 8'd0;
    logic [15:0] cpu_pc = 16'd0;
    logic        cpu_boundary = 1'b0;
    logic        take_irq;
    logic [15:0] handler_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";

    // behavioural reference
    logic [15:0] m_ret, m_hnd;
    logic [7:0]  m_mask, m_pend, m_reqq;
    bit          m_take;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .cpu_pc(cpu_pc), .cpu_boundary(cpu_boundary), .take_irq(take_irq),
        .handler_addr(handler_addr)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ret = 0; m_hnd = 0; m_mask = 8'hFF; m_pend = 0; m_reqq = 0; m_take = 0;
        end else begin
            logic [7:0] rs;
            bit tk;
            rs = irq_req & ~m_reqq & 8'h3F;
            m_reqq = irq_req;
            tk = !m_take && cpu_boundary && ((m_pend & ~m_mask) != 0);
            if (reg_wr && reg_addr == 3) m_pend = m_pend & reg_wdata;
            m_pend = (m_pend | rs) & 8'h3F;
            if (tk) m_mask = 8'hFF;
            else if (reg_wr && reg_addr == 2) m_mask = reg_wdata;
            if (reg_wr && reg_addr == 4) m_hnd[7:0] = reg_wdata;
            if (reg_wr && reg_addr == 5) m_hnd[15:8] = reg_wdata;
            if (tk) m_ret = cpu_pc;
            m_take = tk;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ret[7:0];
            3'd1: return m_ret[15:8];
            3'd2: return m_mask;
            3'd3: return m_pend;
            3'd4: return m_hnd[7:0];
            3'd5: return m_hnd[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // wait to the falling edge and compare everything visible
    task automatic tick();
        @(negedge clk);
        check("rdata", 32'(reg_rdata), 32'(exp_rd(reg_addr)));
        check("take", 32'(take_irq), 32'(m_take));
        check("handler", 32'(handler_addr), 32'(m_hnd));
    endtask

    task automatic idle();
        reg_wr = 0; cpu_boundary = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
    endtask

    task automatic rd_all();
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a); tick();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1"; rd_all();                       // R1 reset state
        tag = "R10"; wr(4, 8'h34); wr(5, 8'h12); rd_all(); // R10 byte lanes
        check("handler literal", 32'(handler_addr), 32'h1234);
        tag = "R9"; wr(0, 8'hAA); wr(1, 8'h55); rd_all(); // R9 return is read-only
        tag = "R2"; wr(2, 8'h00);
        irq_req[2] = 1; reg_addr = 3; tick(); tick();      // R2 rise sets pending
        check("pend bit2", 32'(reg_rdata), 32'h04);
        tag = "R11"; repeat (3) tick();                     // R11 no boundary, no take
        tag = "R7"; cpu_pc = 16'hBEEF; cpu_boundary = 1; tick(); idle();
        check("take literal", 32'(take_irq), 32'h1);        // R7
        tick();
        tag = "R8"; rd_all();                               // R8 ret and mask
        reg_addr = 0; tick(); check("ret lo literal", 32'(reg_rdata), 32'hEF);
        tag = "R3"; wr(3, 8'hFB); reg_addr = 3; tick();     // R3 clear by zero
        check("pend cleared", 32'(reg_rdata), 32'h00);
        tag = "R2"; repeat (2) tick();                      // R2 held level no reset
        irq_req = 0; tick();
        tag = "R3"; irq_req = 8'h03; tick(); irq_req = 0;
        wr(3, 8'hFE); reg_addr = 3; tick();                 // R3 only bit0 cleared
        check("pend bit1 kept", 32'(reg_rdata), 32'h02);
        tag = "R4"; irq_req[0] = 1; wr(3, 8'h00); reg_addr = 3; tick(); // R4 set wins
        check("set wins", 32'(reg_rdata), 32'h01);
        irq_req = 0; wr(3, 8'h00);
        tag = "R5"; irq_req = 8'hC0; tick(); irq_req = 0; wr(3, 8'hFF); reg_addr = 3; tick(); // R5
        check("rsvd zero", 32'(reg_rdata), 32'h00);
        tag = "R6"; wr(2, 8'h08); irq_req[3] = 1; tick(); irq_req = 0;
        cpu_boundary = 1; repeat (3) tick(); idle();         // R6 masked source
        check("no take masked", 32'(take_irq), 32'h0);
        tag = "R8"; cpu_pc = 16'h4321; cpu_boundary = 1;
        reg_wr = 1; reg_addr = 2; reg_wdata = 8'h00; tick(); // unmask; take next edge
        reg_wdata = 8'h11; tick(); idle();                   // R8 mask write loses to entry
        reg_addr = 2; tick(); check("mask forced", 32'(reg_rdata), 32'hFF);
        rd_all();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog %s: actual hung expected finish", tag);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule